// File: doc/BRIEF.md
# PCIe Receive Packet Router

This block sits behind the receive side of a PCI Express endpoint. The endpoint delivers packets as 64-bit beats. Active-low strobes mark the first beat, the last beat and each valid beat. The router decodes the format/type field of the first header dword and then handles each packet according to its kind:

- A 3-dword memory write that targets the block's 128-byte window updates one word of a small register file.
- A 3-dword memory read captures the requester identity, tag, length, low address bits and the addressed register's value into a completion request. That request is held for the transmit side until the transmit side acknowledges it.
- A completion with data has its payload dwords pushed, in order, into a receive FIFO that the downstream consumer drains.
- Every other packet type is discarded up to its last beat.

The router holds off the endpoint by dropping its ready output in two cases. The first is when the FIFO cannot take another full beat. The second is at a packet boundary while a completion request is still waiting, so that only one request is ever outstanding.

Beat layout: the earlier dword of each beat is in bits [63:32] and the later dword is in bits [31:0]. The first beat carries header dwords 0 and 1. The second beat carries header dword 2 and, for packets with data, the first payload dword.

Top module: `rx_tlp_router_top`

## Requirements
- R1: After reset, rx_ready_o is 1, cpl_req_o is 0, rxq_valid_o is 0 and every register in regs_o is zero.
- R2: The packet kind is taken from bits [62:56] of the first beat, which is header dword 0 bits [30:24]. The value 0x00 is a memory read, 0x40 is a memory write and 0x4A is a completion with data. The length is taken from bits [41:32] of the first beat. A beat accepted with rx_sof_ni high, outside a packet, is discarded.
- R3: A memory write selects register index address bits [6:2], taken from second-beat bits [38:34]. If the index is below NUM_REGS, that register takes the first payload dword (second-beat bits [31:0]). The new value appears on regs_o in the cycle after the beat is accepted.
- R4: A memory write whose index is NUM_REGS or above leaves every register unchanged.
- R5: In the cycle after a memory read's second beat is accepted, cpl_req_o rises and the request fields carry the following values:
  - requester ID from first-beat bits [31:16];
  - tag from first-beat bits [15:8];
  - length from first-beat bits [41:32];
  - lower address from second-beat bits [38:32];
  - data equal to the addressed register, or zero for an index of NUM_REGS or above.
- R6: The completion request and its fields hold steady until the cycle in which cpl_ack_i is 1. In the following cycle, cpl_req_o is 0.
- R7: While a completion request is outstanding and no packet is in progress, rx_ready_o is 0, so no new packet starts.
- R8: The payload dwords of a completion with data, as many as its length field gives, enter the receive FIFO in packet order: earlier dword first within a beat. A dword slot beyond the length is not stored. Beats with rx_valid_ni high are ignored, whatever the other strobes and data are.
- R9: rx_ready_o is 0 whenever the receive FIFO has fewer than two free entries. No payload dword is lost when the FIFO fills and later drains.
- R10: A packet of any other type is dropped up to its last beat. It changes no register, pushes nothing into the FIFO and raises no completion request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 64 | Receive beat data |
| rx_sof_ni | input | 1 | First beat of packet, active low |
| rx_eof_ni | input | 1 | Last beat of packet, active low |
| rx_valid_ni | input | 1 | Beat valid, active low |
| rx_ready_o | output | 1 | Router can accept a beat |
| regs_o | output | NUM_REGS*32 | Register file contents, register i at bits [i*32 +: 32] |
| cpl_req_o | output | 1 | Completion request pending |
| cpl_ack_i | input | 1 | Transmit side takes the request |
| cpl_req_id_o | output | 16 | Requester ID of the read |
| cpl_tag_o | output | 8 | Tag of the read |
| cpl_len_o | output | 10 | Length field of the read |
| cpl_lower_addr_o | output | 7 | Address bits [6:0] of the read |
| cpl_data_o | output | 32 | Register value for the completion |
| rxq_valid_o | output | 1 | Receive FIFO not empty |
| rxq_data_o | output | 32 | Receive FIFO head dword |
| rxq_pop_i | input | 1 | Consumer removes the head dword |

## Verification
The hardest situation to reach is a completion whose payload exceeds the FIFO while the consumer is stalled. In that case ready must fall in the middle of a packet and recover without dropping or reordering dwords. The bench reaches it by disabling pops, sending a 20-dword completion into the 16-entry FIFO, and re-enabling pops from a parallel process after the stall has been seen.

A second hard case is a read that arrives while another completion request is still waiting for its acknowledgement. The bench creates it by stretching the acknowledgement delay and sending two reads back to back.

// File: rtl/rx_tlp_pkg.sv
package rx_tlp_pkg;

  localparam int IDX_W = 5;  // 128-byte window, dword index

  localparam logic [6:0] FT_MRD32 = 7'h00;
  localparam logic [6:0] FT_MWR32 = 7'h40;
  localparam logic [6:0] FT_CPLD  = 7'h4A;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR2, ST_DATA, ST_SKIP} rx_state_e;
  typedef enum logic [1:0] {K_MRD, K_MWR, K_CPLD, K_OTHER} tlp_kind_e;

  typedef struct packed {
    logic [15:0] req_id;
    logic [7:0]  tag;
    logic [9:0]  len;
    logic [6:0]  lo_addr;
    logic [31:0] data;
  } cpl_req_t;

  function automatic tlp_kind_e decode_kind(input logic [6:0] ft);
    case (ft)
      FT_MRD32: return K_MRD;
      FT_MWR32: return K_MWR;
      FT_CPLD:  return K_CPLD;
      default:  return K_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/rx_tlp_router.sv
module rx_tlp_router
  import rx_tlp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [63:0]      beat_i,
  input  logic             sof_ni,
  input  logic             eof_ni,
  input  logic             valid_ni,
  input  logic             ready_i,
  output logic             idle_o,
  output logic             reg_we_o,
  output logic [IDX_W-1:0] reg_idx_o,
  output logic [31:0]      reg_wdata_o,
  output logic             rd_req_o,
  output logic [15:0]      rd_rid_o,
  output logic [7:0]       rd_tag_o,
  output logic [9:0]       rd_len_o,
  output logic [6:0]       rd_lo_addr_o,
  output logic             push_hi_o,
  output logic             push_lo_o,
  output logic [31:0]      hi_word_o,
  output logic [31:0]      lo_word_o
);

  rx_state_e   state_q;
  tlp_kind_e   kind_q;
  logic [10:0] rem_q;
  logic [15:0] rid_q;
  logic [7:0]  tag_q;
  logic [9:0]  len_q;
  logic        accept;

  assign accept    = !valid_ni && ready_i;
  assign idle_o    = (state_q == ST_IDLE);
  assign hi_word_o = beat_i[63:32];
  assign lo_word_o = beat_i[31:0];

  // second beat: dword 2 in the upper half holds the address
  assign reg_idx_o    = beat_i[38:34];
  assign reg_wdata_o  = beat_i[31:0];
  assign rd_lo_addr_o = beat_i[38:32];
  assign rd_rid_o     = rid_q;
  assign rd_tag_o     = tag_q;
  assign rd_len_o     = len_q;

  always_comb begin
    reg_we_o  = 1'b0;
    rd_req_o  = 1'b0;
    push_hi_o = 1'b0;
    push_lo_o = 1'b0;
    if (accept) begin
      case (state_q)
        ST_HDR2: begin
          case (kind_q)
            K_MRD:   rd_req_o  = 1'b1;
            K_MWR:   reg_we_o  = 1'b1;
            K_CPLD:  push_lo_o = (rem_q != '0);
            default: ;
          endcase
        end
        ST_DATA: begin
          push_hi_o = (rem_q >= 11'd1);
          push_lo_o = (rem_q >= 11'd2);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= K_OTHER;
      rem_q   <= '0;
      rid_q   <= '0;
      tag_q   <= '0;
      len_q   <= '0;
    end else if (accept) begin
      case (state_q)
        ST_IDLE: begin
          if (!sof_ni) begin
            kind_q  <= decode_kind(beat_i[62:56]);
            len_q   <= beat_i[41:32];
            rem_q   <= (beat_i[41:32] == '0) ? 11'd1024 : {1'b0, beat_i[41:32]};
            rid_q   <= beat_i[31:16];
            tag_q   <= beat_i[15:8];
            state_q <= eof_ni ? ST_HDR2 : ST_IDLE;
          end
        end
        ST_HDR2: begin
          rem_q <= rem_q - 11'(push_lo_o);
          if (!eof_ni)               state_q <= ST_IDLE;
          else if (kind_q == K_CPLD) state_q <= ST_DATA;
          else                       state_q <= ST_SKIP;
        end
        ST_DATA: begin
          rem_q <= rem_q - 11'(push_hi_o) - 11'(push_lo_o);
          if (!eof_ni) state_q <= ST_IDLE;
        end
        default: if (!eof_ni) state_q <= ST_IDLE;
      endcase
    end
  end

  AST_PUSH_ONLY_CPLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_hi_o || push_lo_o) |-> (kind_q == K_CPLD)); // R8

  AST_DROP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !(reg_we_o || rd_req_o || push_hi_o || push_lo_o)); // R10

endmodule

// File: rtl/rx_tlp_regs.sv
module rx_tlp_regs
  import rx_tlp_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       widx_i,
  input  logic [31:0]            wdata_i,
  input  logic [IDX_W-1:0]       ridx_i,
  output logic [31:0]            rdata_o,
  output logic [NUM_REGS*32-1:0] regs_o
);

  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [31:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[i] <= '0;
      else if (we_i && (int'(widx_i) == i))     regs_q[i] <= wdata_i;
    end
    assign regs_o[i*32 +: 32] = regs_q[i];
  end

  // out-of-window indices read as zero
  assign rdata_o = (int'(ridx_i) < NUM_REGS) ? regs_q[ridx_i[SEL_W-1:0]] : '0;

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (int'(widx_i) >= NUM_REGS)) |=> $stable(regs_o)); // R4

endmodule

// File: rtl/rx_tlp_cpl_hold.sv
module rx_tlp_cpl_hold
  import rx_tlp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  cpl_req_t fields_i,
  input  logic     ack_i,
  output logic     pending_o,
  output cpl_req_t fields_o
);

  logic     pend_q;
  cpl_req_t fields_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      fields_q <= '0;
    end else if (load_i) begin
      pend_q   <= 1'b1;
      fields_q <= fields_i;
    end else if (pend_q && ack_i) begin
      pend_q   <= 1'b0;
    end
  end

  assign pending_o = pend_q;
  assign fields_o  = fields_q;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !pend_q); // R7

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_i) |=> (pend_q && $stable(fields_q))); // R6

  AST_REQ_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && ack_i) |=> !pend_q); // R6

endmodule

// File: rtl/rx_tlp_fifo.sv
module rx_tlp_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_a_i,
  input  logic [W-1:0]               a_i,
  input  logic                       push_b_i,
  input  logic [W-1:0]               b_i,
  input  logic                       pop_i,
  output logic                       valid_o,
  output logic [W-1:0]               data_o,
  output logic [$clog2(DEPTH+1)-1:0] free_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q, wp_b;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  assign pop     = pop_i && (cnt_q != '0);
  assign wp_b    = wp_q + PTR_W'(push_a_i);
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rp_q];
  assign free_o  = CNT_W'(DEPTH) - cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_a_i) mem_q[wp_q] <= a_i;
    if (push_b_i) mem_q[wp_b] <= b_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_q + PTR_W'(push_a_i) + PTR_W'(push_b_i);
      rp_q  <= rp_q + PTR_W'(pop);
      cnt_q <= cnt_q + CNT_W'(push_a_i) + CNT_W'(push_b_i) - CNT_W'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(push_a_i) + int'(push_b_i)) <= int'(free_o)); // R9

endmodule

// File: rtl/rx_tlp_router_top.sv
module rx_tlp_router_top
  import rx_tlp_pkg::*;
#(
  parameter int NUM_REGS   = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [63:0]            rx_data_i,
  input  logic                   rx_sof_ni,
  input  logic                   rx_eof_ni,
  input  logic                   rx_valid_ni,
  output logic                   rx_ready_o,
  output logic [NUM_REGS*32-1:0] regs_o,
  output logic                   cpl_req_o,
  input  logic                   cpl_ack_i,
  output logic [15:0]            cpl_req_id_o,
  output logic [7:0]             cpl_tag_o,
  output logic [9:0]             cpl_len_o,
  output logic [6:0]             cpl_lower_addr_o,
  output logic [31:0]            cpl_data_o,
  output logic                   rxq_valid_o,
  output logic [31:0]            rxq_data_o,
  input  logic                   rxq_pop_i
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int SLACK = 2;  // one full beat of payload

  logic             idle, pending;
  logic             reg_we, rd_req, push_hi, push_lo;
  logic [IDX_W-1:0] reg_idx;
  logic [31:0]      reg_wdata, rd_data, hi_word, lo_word;
  logic [15:0]      rd_rid;
  logic [7:0]       rd_tag;
  logic [9:0]       rd_len;
  logic [6:0]       rd_lo_addr;
  logic [CNT_W-1:0] free;
  cpl_req_t         req_in, req_out;

  assign rx_ready_o = (int'(free) >= SLACK) && !(idle && pending);

  rx_tlp_router u_router (
    .clk_i, .rst_ni,
    .beat_i       (rx_data_i),
    .sof_ni       (rx_sof_ni),
    .eof_ni       (rx_eof_ni),
    .valid_ni     (rx_valid_ni),
    .ready_i      (rx_ready_o),
    .idle_o       (idle),
    .reg_we_o     (reg_we),
    .reg_idx_o    (reg_idx),
    .reg_wdata_o  (reg_wdata),
    .rd_req_o     (rd_req),
    .rd_rid_o     (rd_rid),
    .rd_tag_o     (rd_tag),
    .rd_len_o     (rd_len),
    .rd_lo_addr_o (rd_lo_addr),
    .push_hi_o    (push_hi),
    .push_lo_o    (push_lo),
    .hi_word_o    (hi_word),
    .lo_word_o    (lo_word)
  );

  rx_tlp_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni,
    .we_i    (reg_we),
    .widx_i  (reg_idx),
    .wdata_i (reg_wdata),
    .ridx_i  (reg_idx),
    .rdata_o (rd_data),
    .regs_o  (regs_o)
  );

  assign req_in = '{req_id: rd_rid, tag: rd_tag, len: rd_len,
                    lo_addr: rd_lo_addr, data: rd_data};

  rx_tlp_cpl_hold u_cpl (
    .clk_i, .rst_ni,
    .load_i    (rd_req),
    .fields_i  (req_in),
    .ack_i     (cpl_ack_i),
    .pending_o (pending),
    .fields_o  (req_out)
  );

  assign cpl_req_o        = pending;
  assign cpl_req_id_o     = req_out.req_id;
  assign cpl_tag_o        = req_out.tag;
  assign cpl_len_o        = req_out.len;
  assign cpl_lower_addr_o = req_out.lo_addr;
  assign cpl_data_o       = req_out.data;

  rx_tlp_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk_i, .rst_ni,
    .push_a_i (push_hi),
    .a_i      (hi_word),
    .push_b_i (push_lo),
    .b_i      (lo_word),
    .pop_i    (rxq_pop_i),
    .valid_o  (rxq_valid_o),
    .data_o   (rxq_data_o),
    .free_o   (free)
  );

  AST_NO_START_WHILE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && pending) |-> !rx_ready_o); // R7

endmodule

// File: tb/rx_tlp_router_top_tb.sv
module rx_tlp_router_top_tb;

  localparam int NREG  = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] rx_data = '0;
  logic sof_n = 1'b1, eof_n = 1'b1, valid_n = 1'b1;
  logic ack = 1'b0, pop = 1'b0;
  logic rx_ready_o, cpl_req_o, rxq_valid_o;
  logic [NREG*32-1:0] regs_o;
  logic [15:0] cpl_req_id_o;
  logic [7:0]  cpl_tag_o;
  logic [9:0]  cpl_len_o;
  logic [6:0]  cpl_lower_addr_o;
  logic [31:0] cpl_data_o, rxq_data_o;

  always #2.5 clk = ~clk;

  rx_tlp_router_top #(.NUM_REGS(NREG), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_data_i(rx_data), .rx_sof_ni(sof_n), .rx_eof_ni(eof_n), .rx_valid_ni(valid_n),
    .rx_ready_o, .regs_o, .cpl_req_o, .cpl_ack_i(ack),
    .cpl_req_id_o, .cpl_tag_o, .cpl_len_o, .cpl_lower_addr_o, .cpl_data_o,
    .rxq_valid_o, .rxq_data_o, .rxq_pop_i(pop)
  );

  int total = 0, bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          ms;       // 0 idle, 1 second beat, 2 payload, 3 discard
  int          mk;       // 0 read, 1 write, 2 completion, 3 other
  int          mrem;
  logic [31:0] mregs [NREG];
  logic [31:0] q [$];
  bit          mpend;
  logic [15:0] m_rid, m_req_rid;
  logic [7:0]  m_tag, m_req_tag;
  logic [9:0]  m_len, m_req_len;
  logic [6:0]  m_req_lo;
  logic [31:0] m_req_data;
  bit          m_rdy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mk = 3; mrem = 0; mpend = 0; q.delete();
      foreach (mregs[i]) mregs[i] = '0;
      m_req_rid = '0; m_req_tag = '0; m_req_len = '0; m_req_lo = '0; m_req_data = '0;
      m_rid = '0; m_tag = '0; m_len = '0;
    end else begin
      bit acc;
      int idx;
      acc = !valid_n && (q.size() <= DEPTH - 2) && !(ms == 0 && mpend);
      if (mpend && ack) mpend = 0;
      if (pop && q.size() > 0) void'(q.pop_front());
      if (acc) begin
        idx = int'(rx_data[38:34]);
        case (ms)
          0: if (!sof_n) begin
               case (rx_data[62:56])
                 7'h00: mk = 0;
                 7'h40: mk = 1;
                 7'h4A: mk = 2;
                 default: mk = 3;
               endcase
               m_len = rx_data[41:32];
               mrem  = (m_len == 0) ? 1024 : int'(m_len);
               m_rid = rx_data[31:16];
               m_tag = rx_data[15:8];
               ms = eof_n ? 1 : 0;
             end
          1: begin
               if (mk == 0) begin
                 mpend = 1; m_req_rid = m_rid; m_req_tag = m_tag; m_req_len = m_len;
                 m_req_lo = rx_data[38:32];
                 m_req_data = (idx < NREG) ? mregs[idx] : 32'h0;
               end else if (mk == 1) begin
                 if (idx < NREG) mregs[idx] = rx_data[31:0];
               end else if (mk == 2 && mrem > 0) begin
                 q.push_back(rx_data[31:0]); mrem--;
               end
               ms = !eof_n ? 0 : (mk == 2 ? 2 : 3);
             end
          2: begin
               if (mrem > 0) begin q.push_back(rx_data[63:32]); mrem--; end
               if (mrem > 0) begin q.push_back(rx_data[31:0]);  mrem--; end
               if (!eof_n) ms = 0;
             end
          default: if (!eof_n) ms = 0;
        endcase
      end
    end
    m_rdy = (q.size() <= DEPTH - 2) && !(ms == 0 && mpend);
  end

  bit running = 0;
  always @(negedge clk) begin
    if (rst_n && running) begin
      chk("R7 R9 ready", rx_ready_o, m_rdy);
      chk("R5 R6 cpl_req", cpl_req_o, mpend);
      if (mpend) begin
        chk("R5 req_id", cpl_req_id_o, m_req_rid);
        chk("R5 tag", cpl_tag_o, m_req_tag);
        chk("R5 len", cpl_len_o, m_req_len);
        chk("R5 lower_addr", cpl_lower_addr_o, m_req_lo);
        chk("R5 data", cpl_data_o, m_req_data);
      end
      chk("R8 rxq_valid", rxq_valid_o, q.size() > 0);
      if (q.size() > 0) chk("R8 rxq_data", rxq_data_o, q[0]);
      for (int i = 0; i < NREG; i++) chk("R3 R4 R10 regs", regs_o[i*32 +: 32], mregs[i]);
    end
  end

  // ---------------- consumer and transmit-side responders ----------------
  int ack_delay = 2, wc = 0;
  always @(negedge clk) begin
    if (!rst_n) begin ack = 0; wc = 0; end
    else if (cpl_req_o && !ack) begin
      wc++;
      if (wc >= ack_delay) begin ack = 1; wc = 0; end
    end else ack = 0;
  end

  bit pop_en = 1;
  int ph = 0;
  always @(negedge clk) begin
    ph++;
    pop = pop_en && (ph % 3 != 0);
  end

  bit watch_full = 0, saw_stall = 0;
  always @(negedge clk) if (watch_full && !pop_en && !rx_ready_o && !cpl_req_o) saw_stall = 1;

  // ---------------- stimulus ----------------
  task automatic beat(input logic [63:0] d, input bit sof, input bit eof);
    rx_data = d; sof_n = !sof; eof_n = !eof; valid_n = 0;
    while (!rx_ready_o) @(negedge clk);
    @(negedge clk);
    valid_n = 1; sof_n = 1; eof_n = 1;
  endtask

  task automatic gap(input int n);
    rx_data = 64'hBAD0_BAD0_BAD0_BAD0; sof_n = 0; eof_n = 0; valid_n = 1;
    repeat (n) @(negedge clk);
    sof_n = 1; eof_n = 1;
  endtask

  function automatic logic [31:0] dw0(input logic [6:0] ft, input logic [9:0] len);
    return {1'b0, ft, 14'h0, len};
  endfunction

  task automatic mwr(input logic [6:0] addr, input logic [31:0] d);
    beat({dw0(7'h40, 10'd1), 32'h0200_00FF}, 1, 0);
    beat({25'h0080000, addr, d}, 0, 1);
  endtask

  task automatic mrd(input logic [6:0] addr, input logic [15:0] rid, input logic [7:0] tag,
                     input logic [9:0] len);
    beat({dw0(7'h00, len), rid, tag, 8'hFF}, 1, 0);
    beat({25'h0080000, addr, 32'h0}, 0, 1);
  endtask

  task automatic cpld(input int len, input logic [31:0] base, input bit gaps);
    int k;
    beat({dw0(7'h4A, 10'(len)), 32'h0100_0000 | 32'(len * 4)}, 1, 0);
    if (gaps) gap(2);
    beat({32'h0300_0000, base}, 0, len == 1);
    k = 1;
    while (k < len) begin
      logic [31:0] lo;
      lo = (k + 1 < len) ? base + 32'(k + 1) : 32'hDEAD_BEEF;
      if (gaps) gap(1);
      beat({base + 32'(k), lo}, 0, k + 2 >= len);
      k += 2;
    end
  endtask

  bit finished = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", rx_ready_o, 1);
    chk("R1 cpl_req", cpl_req_o, 0);
    chk("R1 rxq_valid", rxq_valid_o, 0);
    chk("R1 regs", regs_o, '0);
    running = 1;

    // R3 R4 writes, R2 stray beat without start strobe
    mwr(7'h04, 32'hA5A5_0001);
    mwr(7'h1C, 32'h7777_0007);
    mwr(7'h40, 32'hFFFF_FFFF);  // index 16: ignored (R4)
    beat({dw0(7'h40, 10'd1), 32'h0}, 0, 0);  // no sof: discarded (R2)
    @(negedge clk);
    chk("R3 reg1", regs_o[1*32 +: 32], 32'hA5A5_0001);
    chk("R3 reg7", regs_o[7*32 +: 32], 32'h7777_0007);
    chk("R4 reg0", regs_o[0 +: 32], 32'h0);

    // R5 read of a defined register
    ack_delay = 3;
    mrd(7'h05, 16'h0123, 8'h45, 10'd1);
    chk("R5 req raised", cpl_req_o, 1);
    chk("R5 data", cpl_data_o, 32'hA5A5_0001);
    chk("R5 lower_addr", cpl_lower_addr_o, 7'h05);
    while (cpl_req_o) @(negedge clk);

    // R7 second read while first waits
    ack_delay = 10;
    mrd(7'h1C, 16'hBEEF, 8'h11, 10'd1);
    chk("R7 ready held low", rx_ready_o, 0);
    mrd(7'h50, 16'h4321, 8'h22, 10'd1);  // index 20: data zero (R5)
    chk("R5 oor data", cpl_data_o, 32'h0);
    ack_delay = 2;
    while (cpl_req_o) @(negedge clk);

    // R8 completions, gaps with stray strobes while not valid
    cpld(1, 32'h1000_0000, 0);
    cpld(2, 32'h2000_0000, 1);
    cpld(5, 32'h3000_0000, 1);
    cpld(6, 32'h4000_0000, 0);

    // R10 other types dropped
    beat({dw0(7'h60, 10'd1), 32'h0}, 1, 0);
    beat({32'h0, 32'h0000_0008}, 0, 0);
    beat({32'hDEAD_0002, 32'h0}, 0, 1);
    beat({dw0(7'h0A, 10'd0), 32'h0}, 1, 0);
    beat({32'h0000_0008, 32'h5555_5555}, 0, 1);
    repeat (20) @(negedge clk);
    chk("R10 reg2", regs_o[2*32 +: 32], 32'h0);
    chk("R10 no push", rxq_valid_o, 0);
    chk("R10 no req", cpl_req_o, 0);

    // R9 fill the FIFO with pops stalled
    pop_en = 0; watch_full = 1;
    fork
      cpld(20, 32'h5000_0000, 0);
      begin repeat (40) @(negedge clk); pop_en = 1; end
    join
    watch_full = 0;
    chk("R9 stall seen", saw_stall, 1);
    repeat (40) @(negedge clk);
    chk("R9 drained", rxq_valid_o, 0);

    // back-to-back write then read of same register
    mwr(7'h08, 32'hCAFE_0002);
    mrd(7'h08, 16'h0001, 8'h03, 10'd1);
    chk("R5 read after write", cpl_data_o, 32'hCAFE_0002);
    repeat (10) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule